// File: doc/BRIEF.md
# TDM Time-Slot Switch Core

This block is a time-slot interchange for a few serial TDM streams. With the default parameters it handles 4 input and 4 output streams of 32 byte-wide channels per frame. Every output stream has its own array of connect words, with one word for each output channel. A connect word puts its channel into one of two modes:

- **Message mode:** the channel sends a fixed byte that the CPU wrote.
- **Connection mode:** the channel sends the byte that a chosen input stream and channel carried in the previous frame.

Each connect word also has a driver-enable bit that gates the pad enable for that time slot. A global enable pin can force every output off.

Bit timing comes from outside the block. An external counter supplies the current channel number and bit number. It also gives a one-cycle `bitTick` strobe at the sample point of each bit. On every tick the block takes in one bit per input stream and moves each output one bit forward. Input bytes go into a two-page data memory: the block writes one page during a frame and reads the other. This gives a fixed switching delay of one frame.

The CPU port is a simple synchronous port. It reaches a control register, the connect memory and the data memory. The address pins give the channel number. The control register gives the stream number and the target region. The data memory can be read but not written.

Top module: `tdm_tsi_switch`

## Requirements
- R1: Reset clears every connect word to zero (driver disabled, connection mode). Until the CPU programs the switch and frames run, `serOutEn` stays all zero.
- R2: When `cpuAddr[CHW]` is 1 (CHW = log2 of the channel count), the access goes to the control register. The control register fields are: bits [SW-1:0] stream number, bit SW selects the high half of the connect word, bit SW+1 selects connect memory instead of data memory. SW is log2 of the stream count. The register reads back what was written, and it resets to 0.
- R3: When `cpuAddr[CHW]` is 0 and connect memory is selected, a write stores `cpuWdata` into the low byte or the high word of the connect entry. The entry is picked by the control-register stream and by `cpuAddr[CHW-1:0]` as the channel. A read returns the stored value.
- R4: When bit 0 of the high word is 1 (message mode), the channel sends its low byte in every frame. A CPU overwrite takes effect from the next time that channel is loaded.
- R5: When bit 0 of the high word is 0 (connection mode), the channel in frame F sends the byte that input frame F-1 carried. The source stream is high-word bits [2+:SW] and the source channel is low-byte bits [CHW-1:0]. This includes the last channel of one frame feeding channel 0 of the next.
- R6: Bit 1 of the high word drives `serOutEn` for that channel's eight bit times only.
- R7: While `outDriveEn` is low, every bit of `serOutEn` is low, whatever the connect words hold.
- R8: Each channel is sent MSB first. The byte is loaded on the tick of bit 7 of the previous channel. After the tick of bit b-1, `serOut` shows bit b.
- R9: A data-memory read returns the most recently stored byte for the selected stream and channel. A channel lower than the current `chanCnt` returns this frame's byte, and any other channel returns the previous frame's byte.
- R10: CPU writes to the data-memory region are ignored. A later read returns the unchanged byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | One-cycle strobe at the sample point of each bit time |
| chanCnt | input | CHW | Current channel number from the external counter |
| bitCnt | input | 3 | Current bit number, 0 is the MSB |
| serIn | input | NUM_STREAMS | Serial input data, one bit per stream |
| serOut | output | NUM_STREAMS | Serial output data, one bit per stream |
| serOutEn | output | NUM_STREAMS | Pad driver enable for each output stream |
| outDriveEn | input | 1 | Global output enable; low forces all pads off |
| cpuSel | input | 1 | CPU access select |
| cpuWr | input | 1 | CPU write (1) or read (0) |
| cpuAddr | input | CHW+1 | Top bit selects the control register; low bits give the channel |
| cpuWdata | input | 8 | CPU write data |
| cpuRdata | output | 8 | CPU read data (combinational) |

## Verification
- **Frame boundary:** the bench routes the last input channel of a frame to output channel 0 of the next frame. A design without forwarding at the page flip would send a byte one frame stale there.
- **Data-memory reads:** the bench reads channels just below and just above the current channel in the middle of a frame. A read that ignored the channel position would return the wrong frame's byte.
- **Message overwrite:** one message byte is overwritten during a frame and checked from that frame onward. A design that latched message bytes only once would keep sending the old byte.
- **Global enable:** the global enable is pulled low for a whole frame. A design with the wrong enable priority would leave pads driving.
- **Enable gating:** a sweep that disables single channels checks that the enable gates one slot at a time.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  // Strobes issued by control to datapath, one set per clock
  typedef struct packed {
    logic sampleBit;  // shift one input bit per stream
    logic storeByte;  // write assembled input bytes to data memory
    logic loadOut;    // load next channel byte into output shifters
    logic shiftOut;   // advance output shifters by one bit
    logic flipPage;   // last bit of frame: swap data memory pages
  } tsiStrobe_t;
endpackage

// File: rtl/tsi_ctrl.sv
module tsi_ctrl
  import tsi_pkg::*;
#(
  parameter int NS   = 4,
  parameter int NC   = 32,
  parameter int SW   = 2,
  parameter int CHW  = 5,
  parameter int CMHW = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     bitTick,
  input  logic [CHW-1:0]           chanCnt,
  input  logic [2:0]               bitCnt,
  input  logic                     cpuSel,
  input  logic                     cpuWr,
  input  logic [CHW:0]             cpuAddr,
  input  logic [7:0]               cpuWdata,
  output logic [7:0]               cpuRdata,
  output tsiStrobe_t               strobe,
  output logic                     wrPage,
  output logic [CHW-1:0]           nextChan,
  output logic [NS-1:0][7:0]       cmLowNext,
  output logic [NS-1:0][CMHW-1:0]  cmHighNext,
  output logic                     dmRdPage,
  output logic [SW-1:0]            dmRdStream,
  output logic [CHW-1:0]           dmRdChan,
  input  logic [7:0]               dmRdByte
);
  localparam int CRW = SW + 2;

  logic [CRW-1:0]  ctrlReg;
  logic [SW-1:0]   crStream;
  logic            crHigh;
  logic            crConn;
  logic            wrEn;
  logic            isCtrl;
  logic [CHW-1:0]  addrChan;
  logic            lastBit;
  logic            lastChan;

  logic [7:0]      cmLow  [NS][NC];
  logic [CMHW-1:0] cmHigh [NS][NC];

  assign crStream = ctrlReg[SW-1:0];
  assign crHigh   = ctrlReg[SW];
  assign crConn   = ctrlReg[SW+1];
  assign wrEn     = cpuSel && cpuWr;
  assign isCtrl   = cpuAddr[CHW];
  assign addrChan = cpuAddr[CHW-1:0];

  // Bit-timing decode
  assign lastBit  = (bitCnt == 3'd7);
  assign lastChan = (chanCnt == CHW'(NC - 1));
  assign nextChan = lastChan ? '0 : chanCnt + CHW'(1);

  always_comb begin
    strobe.sampleBit = bitTick;
    strobe.storeByte = bitTick && lastBit;
    strobe.loadOut   = bitTick && lastBit;
    strobe.shiftOut  = bitTick && !lastBit;
    strobe.flipPage  = bitTick && lastBit && lastChan;
  end

  // Write-page toggle, one page per frame
  always_ff @(posedge clk) begin
    if (!rstN) wrPage <= 1'b0;
    else if (strobe.flipPage) wrPage <= ~wrPage;
  end

  // Control register and connect memory
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      for (int s = 0; s < NS; s++) begin
        for (int c = 0; c < NC; c++) begin
          cmLow[s][c]  <= '0;
          cmHigh[s][c] <= '0;
        end
      end
    end else if (wrEn) begin
      if (isCtrl) begin
        ctrlReg <= cpuWdata[CRW-1:0];
      end else if (crConn) begin
        if (crHigh) cmHigh[crStream][addrChan] <= cpuWdata[CMHW-1:0];
        else        cmLow[crStream][addrChan]  <= cpuWdata;
      end
    end
  end

  // Connect words for the channel about to be loaded
  for (genvar s = 0; s < NS; s++) begin : g_next
    assign cmLowNext[s]  = cmLow[s][nextChan];
    assign cmHighNext[s] = cmHigh[s][nextChan];
  end

  // Data memory read page: channels already stored this frame use wrPage
  assign dmRdStream = crStream;
  assign dmRdChan   = addrChan;
  assign dmRdPage   = (addrChan < chanCnt) ? wrPage : ~wrPage;

  always_comb begin
    if (isCtrl)      cpuRdata = 8'(ctrlReg);
    else if (crConn) cpuRdata = crHigh ? 8'(cmHigh[crStream][addrChan])
                                       : cmLow[crStream][addrChan];
    else             cpuRdata = dmRdByte;
  end

  // R2
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && isCtrl) |=> $stable(ctrlReg));

  // R5
  page_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.flipPage |=> $stable(wrPage));

  // R5
  page_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flipPage |=> (wrPage != $past(wrPage)));

endmodule

// File: rtl/tsi_datapath.sv
module tsi_datapath
  import tsi_pkg::*;
#(
  parameter int NS   = 4,
  parameter int NC   = 32,
  parameter int SW   = 2,
  parameter int CHW  = 5,
  parameter int CMHW = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  tsiStrobe_t               strobe,
  input  logic                     wrPage,
  input  logic [CHW-1:0]           curChan,
  input  logic [CHW-1:0]           nextChan,
  input  logic [NS-1:0]            serIn,
  input  logic [NS-1:0][7:0]       cmLowNext,
  input  logic [NS-1:0][CMHW-1:0]  cmHighNext,
  input  logic                     outDriveEn,
  input  logic                     dmRdPage,
  input  logic [SW-1:0]            dmRdStream,
  input  logic [CHW-1:0]           dmRdChan,
  output logic [7:0]               dmRdByte,
  output logic [NS-1:0]            serOut,
  output logic [NS-1:0]            serOutEn
);
  logic [7:0]         dataMem [2][NS][NC];
  logic [NS-1:0][7:0] inSh;
  logic [NS-1:0][7:0] assembled;
  logic [NS-1:0][7:0] outSh;
  logic [NS-1:0][7:0] selByte;
  logic [NS-1:0]      chEn;
  logic               rdPage;

  // Input byte assembly, MSB first
  for (genvar s = 0; s < NS; s++) begin : g_in
    assign assembled[s] = {inSh[s][6:0], serIn[s]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) inSh <= '0;
    else if (strobe.sampleBit) inSh <= assembled;
  end

  always_ff @(posedge clk) begin
    if (strobe.storeByte) begin
      for (int s = 0; s < NS; s++) dataMem[wrPage][s][curChan] <= assembled[s];
    end
  end

  // Channel 0 of a new frame reads the page being completed now
  assign rdPage = (nextChan == '0) ? wrPage : ~wrPage;

  for (genvar o = 0; o < NS; o++) begin : g_out
    logic [SW-1:0]  srcStream;
    logic [CHW-1:0] srcChan;
    logic           msgMode;
    assign srcStream = cmHighNext[o][2 +: SW];
    assign srcChan   = cmLowNext[o][CHW-1:0];
    assign msgMode   = cmHighNext[o][0];
    always_comb begin
      if (msgMode)
        selByte[o] = cmLowNext[o];
      else if ((rdPage == wrPage) && (srcChan == curChan))
        selByte[o] = assembled[srcStream];   // byte being stored this edge
      else
        selByte[o] = dataMem[rdPage][srcStream][srcChan];
    end
    assign serOut[o] = outSh[o][7];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outSh <= '0;
      chEn  <= '0;
    end else if (strobe.loadOut) begin
      outSh <= selByte;
      for (int o = 0; o < NS; o++) chEn[o] <= cmHighNext[o][1];
    end else if (strobe.shiftOut) begin
      for (int o = 0; o < NS; o++) outSh[o] <= {outSh[o][6:0], 1'b0};
    end
  end

  assign serOutEn = chEn & {NS{outDriveEn}};
  assign dmRdByte = dataMem[dmRdPage][dmRdStream][dmRdChan];

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.loadOut || strobe.shiftOut) |=> $stable(serOut));

  // R6
  en_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadOut |=> $stable(chEn));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (serOutEn == '0));

endmodule

// File: rtl/tdm_tsi_switch.sv
module tdm_tsi_switch
  import tsi_pkg::*;
#(
  parameter int NUM_STREAMS  = 4,
  parameter int NUM_CHANNELS = 32
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              bitTick,
  input  logic [$clog2(NUM_CHANNELS)-1:0]   chanCnt,
  input  logic [2:0]                        bitCnt,
  input  logic [NUM_STREAMS-1:0]            serIn,
  output logic [NUM_STREAMS-1:0]            serOut,
  output logic [NUM_STREAMS-1:0]            serOutEn,
  input  logic                              outDriveEn,
  input  logic                              cpuSel,
  input  logic                              cpuWr,
  input  logic [$clog2(NUM_CHANNELS):0]     cpuAddr,
  input  logic [7:0]                        cpuWdata,
  output logic [7:0]                        cpuRdata
);
  localparam int SW   = $clog2(NUM_STREAMS);
  localparam int CHW  = $clog2(NUM_CHANNELS);
  localparam int CMHW = 2 + SW;

  tsiStrobe_t                     strobe;
  logic                           wrPage;
  logic [CHW-1:0]                 nextChan;
  logic [NUM_STREAMS-1:0][7:0]    cmLowNext;
  logic [NUM_STREAMS-1:0][CMHW-1:0] cmHighNext;
  logic                           dmRdPage;
  logic [SW-1:0]                  dmRdStream;
  logic [CHW-1:0]                 dmRdChan;
  logic [7:0]                     dmRdByte;

  tsi_ctrl #(
    .NS(NUM_STREAMS), .NC(NUM_CHANNELS), .SW(SW), .CHW(CHW), .CMHW(CMHW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .chanCnt(chanCnt), .bitCnt(bitCnt),
    .cpuSel(cpuSel), .cpuWr(cpuWr), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuRdata(cpuRdata), .strobe(strobe), .wrPage(wrPage), .nextChan(nextChan),
    .cmLowNext(cmLowNext), .cmHighNext(cmHighNext), .dmRdPage(dmRdPage),
    .dmRdStream(dmRdStream), .dmRdChan(dmRdChan), .dmRdByte(dmRdByte)
  );

  tsi_datapath #(
    .NS(NUM_STREAMS), .NC(NUM_CHANNELS), .SW(SW), .CHW(CHW), .CMHW(CMHW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrPage(wrPage), .curChan(chanCnt),
    .nextChan(nextChan), .serIn(serIn), .cmLowNext(cmLowNext),
    .cmHighNext(cmHighNext), .outDriveEn(outDriveEn), .dmRdPage(dmRdPage),
    .dmRdStream(dmRdStream), .dmRdChan(dmRdChan), .dmRdByte(dmRdByte),
    .serOut(serOut), .serOutEn(serOutEn)
  );

endmodule

// File: tb/tb_tdm_tsi_switch.sv
module tb_tdm_tsi_switch;
  localparam int NS = 4;
  localparam int NC = 32;
  localparam int CTRL_ADDR = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rstN, bitTick, outDriveEn, cpuSel, cpuWr;
  logic [4:0]    chanCnt;
  logic [2:0]    bitCnt;
  logic [NS-1:0] serIn, serOut, serOutEn;
  logic [5:0]    cpuAddr;
  logic [7:0]    cpuWdata, cpuRdata;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  tdm_tsi_switch #(.NUM_STREAMS(NS), .NUM_CHANNELS(NC)) dut (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .chanCnt(chanCnt), .bitCnt(bitCnt),
    .serIn(serIn), .serOut(serOut), .serOutEn(serOutEn), .outDriveEn(outDriveEn),
    .cpuSel(cpuSel), .cpuWr(cpuWr), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuRdata(cpuRdata)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Stimulus and configuration, computed arithmetically
  function automatic int inByte(int f, int s, int c);
    return (f * 53 + s * 71 + c * 13 + 9) & 255;
  endfunction
  function automatic int isMsg(int c);
    return (c % 4 == 3) ? 1 : 0;
  endfunction
  function automatic int drv(int c);
    return (c % 8 == 5) ? 0 : 1;
  endfunction
  function automatic int srcS(int o, int c);
    return (o + c) % NS;
  endfunction
  function automatic int srcC(int o, int c);
    return (o == 1 && c == 0) ? NC - 1 : (c * 7 + o * 3) % NC;
  endfunction
  function automatic int msgByte(int o, int c, int f);
    return (o == 2 && c == 3 && f >= 4) ? 8'hA5 : (((o * 32) + c) ^ 8'h5A) & 255;
  endfunction
  function automatic int cmhWord(int o, int c);
    return (srcS(o, c) << 2) | (drv(c) << 1) | isMsg(c);
  endfunction
  function automatic int cmlWord(int o, int c);
    return isMsg(c) ? msgByte(o, c, 0) : srcC(o, c);
  endfunction

  task automatic cpuWrite(int a, int d);
    @(negedge clk);
    cpuSel = 1'b1; cpuWr = 1'b1; cpuAddr = a[5:0]; cpuWdata = d[7:0];
    @(negedge clk);
    cpuSel = 1'b0; cpuWr = 1'b0;
  endtask

  task automatic cpuRead(int a, output int d);
    @(negedge clk);
    cpuSel = 1'b1; cpuWr = 1'b0; cpuAddr = a[5:0];
    #1 d = int'(cpuRdata);
    cpuSel = 1'b0;
  endtask

  task automatic setCtrl(int conn, int hi, int s);
    cpuWrite(CTRL_ADDR, (conn << 3) | (hi << 2) | s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired before the run completed");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int d;
    logic [7:0] acc [NS];
    rstN = 1'b0; bitTick = 1'b0; outDriveEn = 1'b1; cpuSel = 1'b0; cpuWr = 1'b0;
    chanCnt = '0; bitCnt = '0; serIn = '0; cpuAddr = '0; cpuWdata = '0;
    for (int o = 0; o < NS; o++) acc[o] = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 enables after reset", int'(serOutEn), 0);
    cpuRead(CTRL_ADDR, d); check("R2 control reset value", d, 0);
    setCtrl(1, 1, 0); cpuRead(5, d);  check("R1 high word cleared", d, 0);
    setCtrl(1, 0, 3); cpuRead(9, d);  check("R1 low byte cleared", d, 0);

    // Program every connect entry
    for (int o = 0; o < NS; o++) begin
      setCtrl(1, 0, o);
      for (int c = 0; c < NC; c++) cpuWrite(c, cmlWord(o, c));
      setCtrl(1, 1, o);
      for (int c = 0; c < NC; c++) cpuWrite(c, cmhWord(o, c));
    end
    check("R1 enables before frames run", int'(serOutEn), 0);
    setCtrl(1, 1, 3); cpuRead(10, d); check("R3 high word readback", d, cmhWord(3, 10));
    setCtrl(1, 0, 1); cpuRead(0, d);  check("R3 low byte readback", d, cmlWord(1, 0));
    cpuRead(CTRL_ADDR, d); check("R2 control readback", d, 9);

    // Frame sweep
    for (int f = 0; f < 7; f++) begin
      for (int c = 0; c < NC; c++) begin
        for (int b = 0; b < 8; b++) begin
          @(negedge clk);
          outDriveEn = (f != 5);
          #1;
          for (int o = 0; o < NS; o++) acc[o] = {acc[o][6:0], serOut[o]};
          if (f >= 1) begin
            if (b == 0) begin
              for (int o = 0; o < NS; o++) begin
                if (f == 5) check("R7 global enable low", int'(serOutEn[o]), 0);
                else        check("R6 channel enable", int'(serOutEn[o]), drv(c));
              end
            end
            if (b == 7 && f != 5) begin
              for (int o = 0; o < NS; o++) begin
                if (drv(c) == 1) begin
                  if (isMsg(c) == 1)
                    check("R4 R8 message byte", int'(acc[o]), msgByte(o, c, f));
                  else
                    check("R5 R8 connection byte", int'(acc[o]),
                          inByte(f - 1, srcS(o, c), srcC(o, c)));
                end
              end
            end
          end
          for (int s = 0; s < NS; s++) begin
            int v;
            v = inByte(f, s, c);
            serIn[s] = v[7 - b];
          end
          chanCnt = c[4:0]; bitCnt = b[2:0]; bitTick = 1'b1;
          @(negedge clk);
          bitTick = 1'b0;
          if (b == 0 && c == 16 && f == 2) begin
            setCtrl(0, 0, 1);
            cpuRead(5, d);  check("R9 read of channel stored this frame", d, inByte(2, 1, 5));
            cpuRead(20, d); check("R9 read of channel not yet stored", d, inByte(1, 1, 20));
            cpuWrite(20, 0);
            cpuRead(20, d); check("R10 data memory write ignored", d, inByte(1, 1, 20));
          end
          if (b == 0 && c == 0 && f == 4) begin
            setCtrl(1, 0, 2);
            cpuWrite(3, 8'hA5);
          end
          if (b == 0 && c == 0 && f == 6) begin
            setCtrl(0, 0, 1);
            cpuRead(31, d); check("R9 read after frame flip", d, inByte(5, 1, 31));
          end
          @(negedge clk);
        end
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule